// File: doc/BRIEF.md
# Receive Buffer with Hysteretic Automatic RTS

This block is the receive-side character store of a serial port. Each character that the receive shifter completes is written together with three error-tag bits (for example parity, framing and break). The oldest entry is always presented at the read head, and a read strobe removes it. The current fill count is exported. A receive-data interrupt is raised while the fill count is at or above a trigger level. The trigger level comes either from a four-entry fixed table or from a programmable value.

The block also drives the active-low request-to-send line `rts_n` by itself. With automatic control running, `rts_n` is released (driven high) once the buffer reaches an upper mark. It is driven low again only after reads have brought the fill count down to a lower mark. The upper and lower marks are set around the trigger level, so the line does not chatter around a single threshold. Characters that the remote side still sends after the release are accepted until the buffer is full.

A low-to-high edge on `rts_n` can latch a status flag and raise an interrupt. A status read clears that flag.

Top module: `rxq_rts_buffer`

## Requirements
- R1: The buffer holds 64 entries of 11 bits, with the character in bits 7:0 and the error tags in bits 10:8. Entries leave in the order they were written. `head_char`/`head_err` show the oldest entry and read as zero while the buffer is empty. A read is accepted only when the buffer is not empty, and it removes exactly one entry.
- R2: A write is accepted only when the fill count is below the capacity. This is checked before any read in the same cycle. A write that is not accepted drops its character and sets `overrun`. `overrun` stays set until a cycle with `line_stat_rd` high and no new drop; a new drop wins over the clear.
- R3: After `rts_n` has been released, writes are still accepted until the fill count reaches 64.
- R4: Automatic control is active only while both `auto_rts_en` and `rts_req` are 1. Otherwise, one cycle later, `rts_n` equals the inverse of `rts_req`, and the release state is cleared. `rts_n` is 1 out of reset.
- R5: With automatic control active, `rts_n` goes high in the cycle after the fill count is at or above the upper mark. After that, it goes low in the cycle after the fill count is at or below the lower mark and below the upper mark. In any other case it holds.
- R6: In programmable mode (`use_table`=0), the trigger is `prog_trig`, with 0 treated as 1 and values above 64 treated as 64. The upper mark is min(trigger+`hyst`, 64). The lower mark is max(trigger-`hyst`, 0).
- R7: In table mode (`use_table`=1), `table_sel` values 0, 1, 2 and 3 select triggers 8, 16, 56 and 60. The upper mark is the next higher table entry, or 64 for select 3. The lower mark is the next lower entry, or 0 for select 0.
- R8: `rx_irq` is 1 exactly while the fill count is at or above the effective trigger. It does not depend on `hyst` or on the RTS state.
- R9: When `rts_irq_en` is 1, a 0-to-1 change of `rts_n` sets `rts_flag`. `rts_stat_rd` clears the flag, but a new edge in the same cycle wins. `rts_irq` is `rts_flag` AND `rts_irq_en`.
- R10: With `fifo_en`=0 the capacity is one entry and the effective trigger for `rx_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the receive shifter |
| wr_char | input | 8 | Character to store |
| wr_err | input | 3 | Error tags stored with the character |
| rd_en | input | 1 | Read strobe; removes the head entry |
| fifo_en | input | 1 | 1: 64-entry buffer, 0: single entry |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| rts_req | input | 1 | Software RTS request; also starts automatic control |
| rts_irq_en | input | 1 | Enables the RTS-change flag and interrupt |
| use_table | input | 1 | 1: fixed table levels, 0: programmable levels |
| table_sel | input | 2 | Fixed table index |
| prog_trig | input | 7 | Programmable trigger level |
| hyst | input | 7 | Programmable hysteresis distance |
| rts_stat_rd | input | 1 | Status read; clears `rts_flag` |
| line_stat_rd | input | 1 | Status read; clears `overrun` |
| head_char | output | 8 | Character at the read head |
| head_err | output | 3 | Error tags at the read head |
| fill_cnt | output | 7 | Number of stored entries |
| overrun | output | 1 | Sticky dropped-write flag |
| rx_irq | output | 1 | Fill count at or above the trigger |
| rts_n | output | 1 | Active-low request to send |
| rts_flag | output | 1 | Latched RTS low-to-high event |
| rts_irq | output | 1 | RTS-change interrupt |

## Verification
The assertions check the following on every cycle:
- the fill count never exceeds the depth;
- a write into a full buffer with no read leaves the count unchanged;
- `overrun` stays set until it is cleared;
- `rts_n` follows the inverse request when automatic control is off;
- `rts_n` releases after the upper mark and re-asserts after the lower mark;
- an enabled RTS edge always sets the flag.

Only the bench scenarios can show the rest:
- the order and content of stored characters and tags;
- the exact table and clamped mark values;
- the one-cycle lag of `rts_n` behind the fill count;
- acceptance of writes all the way to 64 after release;
- the single-entry mode.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int RXQ_DEPTH = 64;
  localparam int RXQ_DW    = 8;
  localparam int RXQ_EW    = 3;

  // Fixed level table, derived from the depth; out-of-range indices clamp.
  function automatic int tbl_level(input int idx, input int depth);
    if (idx < 0) return 0;
    case (idx)
      0:       return depth / 8;
      1:       return depth / 4;
      2:       return (depth * 7) / 8;
      3:       return (depth * 15) / 16;
      default: return depth;
    endcase
  endfunction

  function automatic int prog_level(input int t, input int depth);
    if (t < 1) return 1;
    if (t > depth) return depth;
    return t;
  endfunction

  function automatic int upper_mark(input int t, input int h, input int depth);
    return (t + h > depth) ? depth : t + h;
  endfunction

  function automatic int lower_mark(input int t, input int h);
    return (t > h) ? t - h : 0;
  endfunction

endpackage

// File: rtl/rxq_marks.sv
module rxq_marks #(
  parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          fifo_en,
  input  logic          use_table,
  input  logic [1:0]    table_sel,
  input  logic [CW-1:0] prog_trig,
  input  logic [CW-1:0] hyst,
  output logic [CW-1:0] trig,
  output logic [CW-1:0] hi_mark,
  output logic [CW-1:0] lo_mark
);
  import rxq_pkg::*;

  int t_lvl, u_lvl, l_lvl, sel_i;

  always_comb begin
    sel_i = int'(table_sel);
    if (use_table) begin
      t_lvl = tbl_level(sel_i, DEPTH);
      u_lvl = tbl_level(sel_i + 1, DEPTH);
      l_lvl = tbl_level(sel_i - 1, DEPTH);
    end else begin
      t_lvl = prog_level(int'(prog_trig), DEPTH);
      u_lvl = upper_mark(t_lvl, int'(hyst), DEPTH);
      l_lvl = lower_mark(t_lvl, int'(hyst));
    end
  end

  assign trig    = fifo_en ? CW'(t_lvl) : CW'(1);
  assign hi_mark = CW'(u_lvl);
  assign lo_mark = CW'(l_lvl);

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
  parameter int W     = rxq_pkg::RXQ_DW + rxq_pkg::RXQ_EW,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rp];

endmodule

// File: rtl/rxq_rts_ctl.sv
module rxq_rts_ctl #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] hi_mark,
  input  logic [CW-1:0] lo_mark,
  input  logic          auto_en,
  input  logic          req,
  input  logic          irq_en,
  input  logic          stat_rd,
  output logic          rts_n,
  output logic          rts_next,
  output logic          rts_rise,
  output logic          rts_flag
);
  logic hold, hold_next, active;

  assign active = auto_en & req;

  always_comb begin
    hold_next = hold;
    if (!active)
      hold_next = 1'b0;
    else if (!hold && fill >= hi_mark)
      hold_next = 1'b1;
    else if (hold && fill <= lo_mark && fill < hi_mark)
      hold_next = 1'b0;
  end

  assign rts_next = active ? hold_next : ~req;
  assign rts_rise = ~rts_n & rts_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= 1'b0;
      rts_n    <= 1'b1;
      rts_flag <= 1'b0;
    end else begin
      hold  <= hold_next;
      rts_n <= rts_next;
      if (irq_en && rts_rise) rts_flag <= 1'b1;
      else if (stat_rd)       rts_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/rxq_rts_buffer.sv
module rxq_rts_buffer #(
  parameter int DEPTH = rxq_pkg::RXQ_DEPTH,
  parameter int DW    = rxq_pkg::RXQ_DW,
  parameter int EW    = rxq_pkg::RXQ_EW,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_char,
  input  logic [EW-1:0] wr_err,
  input  logic          rd_en,
  input  logic          fifo_en,
  input  logic          auto_rts_en,
  input  logic          rts_req,
  input  logic          rts_irq_en,
  input  logic          use_table,
  input  logic [1:0]    table_sel,
  input  logic [CW-1:0] prog_trig,
  input  logic [CW-1:0] hyst,
  input  logic          rts_stat_rd,
  input  logic          line_stat_rd,
  output logic [DW-1:0] head_char,
  output logic [EW-1:0] head_err,
  output logic [CW-1:0] fill_cnt,
  output logic          overrun,
  output logic          rx_irq,
  output logic          rts_n,
  output logic          rts_flag,
  output logic          rts_irq
);
  localparam int W = DW + EW;

  logic [W-1:0]  rdata;
  logic [CW-1:0] cap, trig, hi_mark, lo_mark;
  logic          full, empty, push, pop, drop;
  logic          rts_next, rts_rise;

  assign cap   = fifo_en ? CW'(DEPTH) : CW'(1);
  assign full  = fill_cnt >= cap;
  assign empty = fill_cnt == '0;
  assign push  = wr_en & ~full;
  assign pop   = rd_en & ~empty;
  assign drop  = wr_en & full;

  rxq_store #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wdata({wr_err, wr_char}), .rdata(rdata), .count(fill_cnt)
  );

  rxq_marks #(.DEPTH(DEPTH), .CW(CW)) u_marks (
    .fifo_en(fifo_en), .use_table(use_table), .table_sel(table_sel),
    .prog_trig(prog_trig), .hyst(hyst),
    .trig(trig), .hi_mark(hi_mark), .lo_mark(lo_mark)
  );

  rxq_rts_ctl #(.CW(CW)) u_rts (
    .clk(clk), .rst_n(rst_n), .fill(fill_cnt), .hi_mark(hi_mark),
    .lo_mark(lo_mark), .auto_en(auto_rts_en), .req(rts_req),
    .irq_en(rts_irq_en), .stat_rd(rts_stat_rd), .rts_n(rts_n),
    .rts_next(rts_next), .rts_rise(rts_rise), .rts_flag(rts_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            overrun <= 1'b0;
    else if (drop)         overrun <= 1'b1;
    else if (line_stat_rd) overrun <= 1'b0;
  end

  assign head_char = empty ? '0 : rdata[DW-1:0];
  assign head_err  = empty ? '0 : rdata[W-1:DW];
  assign rx_irq    = fill_cnt >= trig;
  assign rts_irq   = rts_flag & rts_irq_en;

endmodule

module rxq_rts_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full,
  input logic          auto_rts_en,
  input logic          rts_req,
  input logic          rts_irq_en,
  input logic          line_stat_rd,
  input logic [CW-1:0] fill_cnt,
  input logic [CW-1:0] hi_mark,
  input logic [CW-1:0] lo_mark,
  input logic          overrun,
  input logic          rts_n,
  input logic          rts_rise,
  input logic          rts_flag
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> $stable(fill_cnt));

  a_r2_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !line_stat_rd) |=> overrun);

  a_r4_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !(auto_rts_en && rts_req) |=> (rts_n == !$past(rts_req)));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rts_req && fill_cnt >= hi_mark) |=> rts_n);

  a_r5_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rts_req && rts_n && fill_cnt <= lo_mark && fill_cnt < hi_mark) |=> !rts_n);

  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_irq_en && rts_rise) |=> rts_flag);
endmodule

bind rxq_rts_buffer rxq_rts_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .full(full),
  .auto_rts_en(auto_rts_en), .rts_req(rts_req), .rts_irq_en(rts_irq_en),
  .line_stat_rd(line_stat_rd), .fill_cnt(fill_cnt), .hi_mark(hi_mark),
  .lo_mark(lo_mark), .overrun(overrun), .rts_n(rts_n), .rts_rise(rts_rise),
  .rts_flag(rts_flag)
);

// File: tb/sim_rxq_rts_buffer.sv
`timescale 1ns/1ps
module sim_rxq_rts_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, fifo_en = 1, auto_rts_en = 0, rts_req = 0;
  logic rts_irq_en = 0, use_table = 0, rts_stat_rd = 0, line_stat_rd = 0;
  logic [7:0] wr_char = 0;
  logic [2:0] wr_err = 0;
  logic [1:0] table_sel = 0;
  logic [6:0] prog_trig = 16, hyst = 8;
  logic [7:0] head_char;
  logic [2:0] head_err;
  logic [6:0] fill_cnt;
  logic overrun, rx_irq, rts_n, rts_flag, rts_irq;

  always #2.5 clk = ~clk;

  rxq_rts_buffer u0 (.*);

  int n_cmp = 0, n_bad = 0;
  logic [10:0] mq[$];
  int  m_hold = 0, m_rtsn = 1, m_flag = 0, m_ovr = 0;
  string rts_tag = "R5";

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void levels(output int t, output int u, output int l);
    int tbl[4] = '{8, 16, 56, 60};
    int s = int'(table_sel), p = int'(prog_trig), h = int'(hyst);
    if (use_table) begin
      t = tbl[s];
      u = (s == 3) ? 64 : tbl[s + 1];
      l = (s == 0) ? 0 : tbl[s - 1];
    end else begin
      t = (p == 0) ? 1 : ((p > 64) ? 64 : p);
      u = (t + h >= 64) ? 64 : t + h;
      l = (h >= t) ? 0 : t - h;
    end
  endfunction

  task automatic compare();
    int t, u, l, cnt;
    levels(t, u, l);
    if (!fifo_en) t = 1;
    cnt = mq.size();
    chk("R1 fill", int'(fill_cnt), cnt);
    chk("R1 head", int'({head_err, head_char}), cnt == 0 ? 0 : int'(mq[0]));
    chk(rts_tag, int'(rts_n), m_rtsn);
    chk("R8 rx_irq", int'(rx_irq), int'(cnt >= t));
    chk("R9 flag", int'(rts_flag), m_flag);
    chk("R9 irq", int'(rts_irq), m_flag & int'(rts_irq_en));
    chk("R2 overrun", int'(overrun), m_ovr);
  endtask

  // One clock: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input bit w, input bit r, input bit sr = 0, input bit lr = 0);
    int t, u, l, cnt, cap, nh, nr;
    bit act, pu, po;
    logic [7:0] c = 8'($urandom);
    logic [2:0] e = 3'($urandom);
    wr_en = w; rd_en = r; rts_stat_rd = sr; line_stat_rd = lr;
    wr_char = c; wr_err = e;
    @(posedge clk);
    levels(t, u, l);
    cnt = mq.size();
    cap = fifo_en ? 64 : 1;
    act = auto_rts_en && rts_req;
    if (!act) nh = 0;
    else if (m_hold == 0 && cnt >= u) nh = 1;
    else if (m_hold == 1 && cnt <= l && cnt < u) nh = 0;
    else nh = m_hold;
    nr = act ? nh : int'(!rts_req);
    if (rts_irq_en && m_rtsn == 0 && nr == 1) m_flag = 1;
    else if (sr) m_flag = 0;
    m_hold = nh; m_rtsn = nr;
    pu = w && (cnt < cap);
    po = r && (cnt > 0);
    if (w && !pu) m_ovr = 1; else if (lr) m_ovr = 0;
    if (po) void'(mq.pop_front());
    if (pu) mq.push_back({e, c});
    @(negedge clk);
    wr_en = 0; rd_en = 0; rts_stat_rd = 0; line_stat_rd = 0;
    compare();
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset fill", int'(fill_cnt), 0);
    chk("R4 reset rts_n", int'(rts_n), 1);
    chk("R8 reset rx_irq", int'(rx_irq), 0);
    chk("R9 reset flag", int'(rts_flag), 0);
    chk("R2 reset overrun", int'(overrun), 0);
    rst_n = 1;
    @(negedge clk);

    // Programmable 16/8: release at 24, re-assert at 8
    auto_rts_en = 1; rts_req = 1; rts_irq_en = 1;
    step(0, 0);
    for (int i = 0; i < 24; i++) step(1, 0);
    chk("R5 lag at 24", int'(rts_n), 0);
    step(0, 0);
    chk("R5 release at 24", int'(rts_n), 1);
    chk("R9 rts_irq on rise", int'(rts_irq), 1);
    step(0, 0, 1);
    chk("R9 cleared by read", int'(rts_flag), 0);
    for (int i = 0; i < 40; i++) step(1, 0);
    chk("R3 accepted to full", int'(fill_cnt), 64);
    step(1, 0);
    chk("R2 drop keeps 64", int'(fill_cnt), 64);
    chk("R2 overrun set", int'(overrun), 1);
    for (int i = 0; i < 55; i++) step(0, 1);
    step(0, 0);
    chk("R5 held at 9", int'(rts_n), 1);
    step(0, 1);
    step(0, 0);
    chk("R5 reassert at 8", int'(rts_n), 0);
    step(0, 0, 0, 1);
    chk("R2 overrun cleared", int'(overrun), 0);

    // Table mode
    rts_tag = "R7";
    for (int i = 0; i < 8; i++) step(0, 1);
    use_table = 1; table_sel = 1;
    for (int i = 0; i < 55; i++) step(1, 0);
    step(0, 0);
    chk("R7 below 56", int'(rts_n), 0);
    step(1, 0);
    step(0, 0);
    chk("R7 release at 56", int'(rts_n), 1);
    table_sel = 3;
    step(0, 0);
    chk("R7 sel3 lower 56", int'(rts_n), 0);
    for (int i = 0; i < 8; i++) step(1, 0);
    step(0, 0);
    chk("R7 sel3 upper clamp 64", int'(rts_n), 1);
    table_sel = 0;
    for (int i = 0; i < 63; i++) step(0, 1);
    step(0, 0);
    chk("R7 sel0 held at 1", int'(rts_n), 1);
    step(0, 1);
    step(0, 0);
    chk("R7 sel0 lower clamp 0", int'(rts_n), 0);

    // Programmable clamps
    rts_tag = "R6";
    use_table = 0; prog_trig = 0; hyst = 0;
    step(1, 0);
    chk("R6 trig 0 as 1", int'(rx_irq), 1);
    step(0, 0);
    chk("R6 upper 1", int'(rts_n), 1);
    step(0, 1);

    // Manual control
    rts_tag = "R4";
    auto_rts_en = 0; rts_req = 1;
    step(0, 0);
    chk("R4 manual low", int'(rts_n), 0);
    rts_req = 0;
    step(0, 0);
    chk("R4 manual high", int'(rts_n), 1);
    auto_rts_en = 1;
    step(0, 0);
    chk("R4 auto without request", int'(rts_n), 1);
    step(0, 0, 1);

    // Single-entry mode
    fifo_en = 0; auto_rts_en = 0;
    step(1, 0);
    step(1, 0);
    chk("R10 capacity one", int'(fill_cnt), 1);
    chk("R10 overrun", int'(overrun), 1);
    chk("R10 trigger one", int'(rx_irq), 1);
    step(0, 1, 0, 1);
    fifo_en = 1;

    // Random traffic
    rts_tag = "R5";
    for (int r = 0; r < 16; r++) begin
      int wp = (r % 2 == 0) ? 75 : 25;
      use_table = 1'($urandom_range(0, 1));
      table_sel = 2'($urandom);
      prog_trig = 7'($urandom_range(0, 70));
      hyst = 7'($urandom_range(0, 20));
      auto_rts_en = ($urandom_range(0, 9) != 0);
      rts_req = ($urandom_range(0, 9) != 0);
      rts_irq_en = 1'($urandom);
      for (int k = 0; k < 180; k++)
        step($urandom_range(0, 99) < wp, $urandom_range(0, 99) >= wp,
             $urandom_range(0, 15) == 0, $urandom_range(0, 31) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule